// File: doc/BRIEF.md
# Segmented Vector Memory Request Sequencer

This block turns one segmented vector load or store into the ordered stream of per-field memory requests that a load/store unit consumes. Each vector element is a small record of consecutive register fields. On a start pulse the block captures a base address, an optional element stride, the byte size of one field, an immediate whose upper bits hold the field count, the vector length, a first register number and the register class and direction. It then walks every field of element 0, then every field of element 1, and so on, presenting each request with a valid/ready handshake.

Before any request leaves the block, the operation is screened: a caller without supervisor rights gets a privileged-operation fault, and a register range that runs past the configured count for the chosen register class gets an illegal-register fault. A faulted operation emits no requests; instead a cause code is shown for one cycle. A clean operation ends with a one-cycle done pulse. Data, memory and register storage sit outside this block.

Top module: `seg_vmem_seq`

## Requirements
- R1: The field count per element is imm_i[11:9] plus one (1 to 8); the other immediate bits have no effect.
- R2: Requests come element by element; within an element, field j is issued with register number reg_base_i + j and element index i, and the same register numbers repeat for every element.
- R3: Within an element, each field address is the previous field address plus elem_bytes_i; the first field of element 0 is at base_addr_i.
- R4: With strided_i low, consecutive element start addresses differ by the field count times elem_bytes_i.
- R5: With strided_i high, consecutive element start addresses differ by stride_i.
- R6: With supervisor_i low at start, no request is issued and xcpt_cause_o shows 1 (privileged); this takes priority over the register check.
- R7: With is_fp_i low, if reg_base_i + fieldcount - 1 is greater than or equal to num_int_regs_i, no request is issued and xcpt_cause_o shows 2 (illegal register); a range ending exactly at num_int_regs_i - 1 is legal.
- R8: With is_fp_i high, the same range check uses num_fp_regs_i instead of num_int_regs_i.
- R9: A vector length of zero issues no request and raises done_o in the cycle after start.
- R10: While req_valid_o is high and req_ready_i low, the request fields stay unchanged; req_store_o repeats is_store_i.
- R11: done_o pulses for one cycle in the cycle after the last request is accepted; xcpt_valid_o pulses for one cycle in the cycle after a faulting start, with xcpt_cause_o 0 outside that pulse.
- R12: Addresses wrap modulo 2 to the power of the address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken when idle |
| base_addr_i | input | 32 | Address of field 0 of element 0 |
| stride_i | input | 32 | Element stride for the strided form |
| strided_i | input | 1 | Selects the strided form |
| elem_bytes_i | input | 4 | Byte size of one field |
| imm_i | input | 12 | Immediate; bits 11:9 hold field count minus one |
| vlen_i | input | 8 | Number of elements |
| reg_base_i | input | 5 | Register number of field 0 |
| is_fp_i | input | 1 | Register class: 1 floating point, 0 integer |
| is_store_i | input | 1 | Direction: 1 store, 0 load |
| supervisor_i | input | 1 | Caller holds supervisor rights |
| num_int_regs_i | input | 6 | Configured integer register count |
| num_fp_regs_i | input | 6 | Configured floating-point register count |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted when high with valid |
| req_addr_o | output | 32 | Request byte address |
| req_elem_o | output | 8 | Element index |
| req_reg_o | output | 5 | Register number |
| req_store_o | output | 1 | Request direction |
| done_o | output | 1 | Operation finished pulse |
| xcpt_valid_o | output | 1 | Fault pulse |
| xcpt_cause_o | output | 2 | Fault cause: 1 privileged, 2 illegal register |

## Verification
The bench aims at the loop nesting and the stepping rules: a design that swapped the loops or advanced the register per element would break the per-request comparison, and one that used the field size as the unit stride would land element 1 on field 1 of element 0. A zero immediate field and a zero vector length are driven, since an off-by-one there either drops or adds a whole element or field. The register range check is hit exactly at the last legal register and one past it, in both register classes, and privilege is tested together with a bad range to catch a wrong fault priority. Back-pressure with an irregular ready pattern and a base near the top of the address space catch requests that drift while stalled and addresses that saturate instead of wrapping.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W  = 32;
    localparam int VL_W    = 8;
    localparam int REG_W   = 5;
    localparam int ESZ_W   = 4;
    localparam int IMM_W   = 12;
    localparam int SEG_LSB = 9;
    localparam int SEG_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2,
        ST_FAULT  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_PRIV    = 2'd1,
        CAUSE_BAD_REG = 2'd2
    } xcpt_cause_e;

    // Field count from the raw immediate field: stored value plus one.
    function automatic logic [SEG_W:0] seg_count(input logic [SEG_W-1:0] fld);
        return {1'b0, fld} + 1'b1;
    endfunction

endpackage

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int SW = SEG_W
) (
    input  logic          supervisor_i,
    input  logic          is_fp_i,
    input  logic [RW-1:0] reg_base_i,
    input  logic [SW:0]   seg_cnt_i,
    input  logic [RW:0]   num_int_i,
    input  logic [RW:0]   num_fp_i,
    output logic          fault_o,
    output xcpt_cause_e   cause_o
);
    localparam int TW = (RW > SW ? RW : SW) + 2;

    logic [TW-1:0] top_reg;
    logic [TW-1:0] limit;
    logic          bad_reg;

    always_comb begin
        top_reg = TW'(reg_base_i) + TW'(seg_cnt_i) - TW'(1);
        limit   = is_fp_i ? TW'(num_fp_i) : TW'(num_int_i);
        bad_reg = (top_reg >= limit);
        if (!supervisor_i) begin
            fault_o = 1'b1;
            cause_o = CAUSE_PRIV;
        end else if (bad_reg) begin
            fault_o = 1'b1;
            cause_o = CAUSE_BAD_REG;
        end else begin
            fault_o = 1'b0;
            cause_o = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int VW = VL_W,
    parameter int RW = REG_W,
    parameter int SW = SEG_W,
    parameter int EW = ESZ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] stride_i,
    input  logic [EW-1:0] esz_i,
    input  logic [SW:0]   seg_cnt_i,
    input  logic [VW-1:0] vlen_i,
    input  logic [RW-1:0] reg_base_i,
    output logic [AW-1:0] addr_o,
    output logic [VW-1:0] elem_o,
    output logic [RW-1:0] reg_o,
    output logic          last_o
);
    logic [AW-1:0] elem_start_q;
    logic [AW-1:0] field_addr_q;
    logic [AW-1:0] stride_q;
    logic [EW-1:0] esz_q;
    logic [SW:0]   seg_q;
    logic [SW:0]   fidx_q;
    logic [VW-1:0] eidx_q;
    logic [VW-1:0] vlen_q;
    logic [RW-1:0] reg_base_q;
    logic          field_wrap;

    assign field_wrap = (fidx_q == seg_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            elem_start_q <= '0;
            field_addr_q <= '0;
            stride_q     <= '0;
            esz_q        <= '0;
            seg_q        <= '0;
            fidx_q       <= '0;
            eidx_q       <= '0;
            vlen_q       <= '0;
            reg_base_q   <= '0;
        end else if (load_i) begin
            elem_start_q <= base_i;
            field_addr_q <= base_i;
            stride_q     <= stride_i;
            esz_q        <= esz_i;
            seg_q        <= seg_cnt_i;
            fidx_q       <= '0;
            eidx_q       <= '0;
            vlen_q       <= vlen_i;
            reg_base_q   <= reg_base_i;
        end else if (adv_i) begin
            if (field_wrap) begin
                fidx_q       <= '0;
                eidx_q       <= eidx_q + 1'b1;
                elem_start_q <= elem_start_q + stride_q;
                field_addr_q <= elem_start_q + stride_q;
            end else begin
                fidx_q       <= fidx_q + 1'b1;
                field_addr_q <= field_addr_q + AW'(esz_q);
            end
        end
    end

    assign addr_o = field_addr_q;
    assign elem_o = eidx_q;
    assign reg_o  = reg_base_q + RW'(fidx_q);
    assign last_o = field_wrap && (eidx_q == vlen_q - 1'b1);

    // R3: inside an element the address advances by one field size
    p_field_step_r3: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && !field_wrap) |=> (addr_o == $past(addr_o) + AW'(esz_q)));

    // R2: the register number advances by one per field inside an element
    p_reg_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i && !field_wrap) |=> (reg_o == $past(reg_o) + 1'b1));

endmodule

// File: rtl/seg_vmem_seq.sv
module seg_vmem_seq
    import seg_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int VW  = VL_W,
    parameter int RW  = REG_W,
    parameter int EW  = ESZ_W,
    parameter int IW  = IMM_W,
    parameter int SL  = SEG_LSB,
    parameter int SW  = SEG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [AW-1:0] stride_i,
    input  logic          strided_i,
    input  logic [EW-1:0] elem_bytes_i,
    input  logic [IW-1:0] imm_i,
    input  logic [VW-1:0] vlen_i,
    input  logic [RW-1:0] reg_base_i,
    input  logic          is_fp_i,
    input  logic          is_store_i,
    input  logic          supervisor_i,
    input  logic [RW:0]   num_int_regs_i,
    input  logic [RW:0]   num_fp_regs_i,
    output logic          req_valid_o,
    input  logic          req_ready_i,
    output logic [AW-1:0] req_addr_o,
    output logic [VW-1:0] req_elem_o,
    output logic [RW-1:0] req_reg_o,
    output logic          req_store_o,
    output logic          done_o,
    output logic          xcpt_valid_o,
    output logic [1:0]    xcpt_cause_o
);
    seq_state_e    state_q;
    xcpt_cause_e   cause_q;
    xcpt_cause_e   chk_cause;
    logic          chk_fault;
    logic [SW:0]   seg_cnt;
    logic [AW-1:0] unit_stride;
    logic [AW-1:0] stride_eff;
    logic          load;
    logic          adv;
    logic          last;
    logic          store_q;
    logic [RW:0]   limit_q;

    assign seg_cnt     = seg_count(imm_i[SL +: SW]);
    assign unit_stride = AW'(seg_cnt) * AW'(elem_bytes_i);
    assign stride_eff  = strided_i ? stride_i : unit_stride;
    assign load        = (state_q == ST_IDLE) && start_i;
    assign adv         = (state_q == ST_ISSUE) && req_ready_i;

    seg_check #(.RW(RW), .SW(SW)) u_check (
        .supervisor_i (supervisor_i),
        .is_fp_i      (is_fp_i),
        .reg_base_i   (reg_base_i),
        .seg_cnt_i    (seg_cnt),
        .num_int_i    (num_int_regs_i),
        .num_fp_i     (num_fp_regs_i),
        .fault_o      (chk_fault),
        .cause_o      (chk_cause)
    );

    seg_addr_gen #(.AW(AW), .VW(VW), .RW(RW), .SW(SW), .EW(EW)) u_agen (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .adv_i      (adv),
        .base_i     (base_addr_i),
        .stride_i   (stride_eff),
        .esz_i      (elem_bytes_i),
        .seg_cnt_i  (seg_cnt),
        .vlen_i     (vlen_i),
        .reg_base_i (reg_base_i),
        .addr_o     (req_addr_o),
        .elem_o     (req_elem_o),
        .reg_o      (req_reg_o),
        .last_o     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
            store_q <= 1'b0;
            limit_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        store_q <= is_store_i;
                        limit_q <= is_fp_i ? num_fp_regs_i : num_int_regs_i;
                        if (chk_fault) begin
                            state_q <= ST_FAULT;
                            cause_q <= chk_cause;
                        end else if (vlen_i == '0) begin
                            state_q <= ST_FINISH;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (req_ready_i && last) state_q <= ST_FINISH;
                end
                ST_FINISH: state_q <= ST_IDLE;
                ST_FAULT: begin
                    state_q <= ST_IDLE;
                    cause_q <= CAUSE_NONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_valid_o  = (state_q == ST_ISSUE);
    assign req_store_o  = store_q;
    assign done_o       = (state_q == ST_FINISH);
    assign xcpt_valid_o = (state_q == ST_FAULT);
    assign xcpt_cause_o = (state_q == ST_FAULT) ? cause_q : CAUSE_NONE;

    // R10: a stalled request keeps every field
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_addr_o) && $stable(req_reg_o) && $stable(req_elem_o)));

    // R7: no issued register lies outside the configured count
    p_reg_legal_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> ({1'b0, req_reg_o} < limit_q));

    // R6: a fault pulse carries a cause and never overlaps a request
    p_fault_silent_r6: assert property (@(posedge clk) disable iff (rst)
        xcpt_valid_o |-> (!req_valid_o && xcpt_cause_o != 2'd0));

    // R11: done and fault are single-cycle pulses
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_xcpt_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        xcpt_valid_o |=> !xcpt_valid_o);

endmodule

// File: tb/seg_vmem_seq_tb.sv
module seg_vmem_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [31:0] stride_i = '0;
    logic        strided_i = 1'b0;
    logic [3:0]  elem_bytes_i = '0;
    logic [11:0] imm_i = '0;
    logic [7:0]  vlen_i = '0;
    logic [4:0]  reg_base_i = '0;
    logic        is_fp_i = 1'b0;
    logic        is_store_i = 1'b0;
    logic        supervisor_i = 1'b1;
    logic [5:0]  num_int_regs_i = 6'd32;
    logic [5:0]  num_fp_regs_i = 6'd32;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic [31:0] req_addr_o;
    logic [7:0]  req_elem_o;
    logic [4:0]  req_reg_o;
    logic        req_store_o;
    logic        done_o;
    logic        xcpt_valid_o;
    logic [1:0]  xcpt_cause_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;   // 50 MHz

    seg_vmem_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .base_addr_i(base_addr_i), .stride_i(stride_i), .strided_i(strided_i),
        .elem_bytes_i(elem_bytes_i), .imm_i(imm_i), .vlen_i(vlen_i),
        .reg_base_i(reg_base_i), .is_fp_i(is_fp_i), .is_store_i(is_store_i),
        .supervisor_i(supervisor_i), .num_int_regs_i(num_int_regs_i),
        .num_fp_regs_i(num_fp_regs_i), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_elem_o(req_elem_o),
        .req_reg_o(req_reg_o), .req_store_o(req_store_o), .done_o(done_o),
        .xcpt_valid_o(xcpt_valid_o), .xcpt_cause_o(xcpt_cause_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic kick(input logic [31:0] base, input logic [31:0] strd, input bit strd_en,
                        input logic [3:0] esz, input logic [11:0] imm, input logic [7:0] vl,
                        input logic [4:0] rb, input bit fp, input bit st, input bit sup,
                        input logic [5:0] nint, input logic [5:0] nfp);
        @(negedge clk);
        base_addr_i = base; stride_i = strd; strided_i = strd_en; elem_bytes_i = esz;
        imm_i = imm; vlen_i = vl; reg_base_i = rb; is_fp_i = fp; is_store_i = st;
        supervisor_i = sup; num_int_regs_i = nint; num_fp_regs_i = nfp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Runs a clean operation and compares every request against the stepping rules.
    task automatic run_ok(input string tag, input logic [31:0] base, input logic [31:0] strd,
                          input bit strd_en, input logic [3:0] esz, input logic [11:0] imm,
                          input logic [7:0] vl, input logic [4:0] rb, input bit fp,
                          input bit st, input bit stall, input logic [5:0] nint,
                          input logic [5:0] nfp);
        int segs   = int'(imm[11:9]) + 1;
        int total  = segs * int'(vl);
        int k      = 0;
        bit prev_last = 1'b0;
        bit ended  = 1'b0;
        logic [31:0] es;
        es = strd_en ? strd : 32'(segs) * 32'(esz);
        kick(base, strd, strd_en, esz, imm, vl, rb, fp, st, 1'b1, nint, nfp);
        for (int t = 0; t < 4000 && !ended; t++) begin
            if (t > 0) @(negedge clk);
            req_ready_i = stall ? ((t % 3) == 1) : 1'b1;
            if (done_o) begin
                check(k == total, {tag, " R11 request count at done"}, k, total);
                check(prev_last, {tag, " R11 done one cycle after last accept"}, prev_last, 1);
                ended = 1'b1;
            end else begin
                prev_last = 1'b0;
                if (req_valid_o) begin
                    int i = k / segs;
                    int j = k % segs;
                    logic [31:0] ea;
                    ea = base + 32'(i) * es + 32'(j) * 32'(esz);
                    check(k < total, {tag, " R2 no extra request"}, k, total);
                    check(req_addr_o == ea, {tag, " R3 R4 R5 R12 address"}, req_addr_o, ea);
                    check(req_reg_o == rb + 5'(j), {tag, " R2 register"}, req_reg_o, rb + 5'(j));
                    check(req_elem_o == 8'(i), {tag, " R2 element index"}, req_elem_o, i);
                    check(req_store_o == st, {tag, " R10 direction"}, req_store_o, st);
                    if (req_ready_i) begin
                        k++;
                        prev_last = (k == total);
                    end
                end
            end
        end
        check(ended, {tag, " R11 done seen"}, ended, 1);
        req_ready_i = 1'b0;
        @(negedge clk);
        check(!done_o && !req_valid_o, {tag, " R11 done single pulse"}, done_o, 0);
    endtask

    task automatic run_fault(input string tag, input logic [4:0] rb, input logic [11:0] imm,
                             input bit fp, input bit sup, input logic [5:0] nint,
                             input logic [5:0] nfp, input logic [1:0] cause);
        kick(32'h2000, 32'h0, 1'b0, 4'd4, imm, 8'd4, rb, fp, 1'b0, sup, nint, nfp);
        req_ready_i = 1'b1;
        check(xcpt_valid_o == 1'b1, {tag, " R11 fault pulse"}, xcpt_valid_o, 1);
        check(xcpt_cause_o == cause, {tag, " R6 R7 R8 cause"}, xcpt_cause_o, cause);
        check(!req_valid_o, {tag, " R6 no request with fault"}, req_valid_o, 0);
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            check(!req_valid_o && !xcpt_valid_o && !done_o && xcpt_cause_o == 2'd0,
                  {tag, " R11 quiet after fault"}, {req_valid_o, xcpt_valid_o, done_o}, 0);
        end
        req_ready_i = 1'b0;
    endtask

    task automatic t_reset();
        check(!req_valid_o && !done_o && !xcpt_valid_o, "reset outputs idle",
              {req_valid_o, done_o, xcpt_valid_o}, 0);
    endtask

    task automatic t_zero_len();
        kick(32'h100, 32'h0, 1'b0, 4'd4, 12'h400, 8'd0, 5'd1, 1'b0, 1'b0, 1'b1, 6'd32, 6'd32);
        check(done_o && !req_valid_o, "R9 zero length done next cycle", done_o, 1);
        @(negedge clk);
        check(!done_o && !req_valid_o, "R9 zero length quiet", {done_o, req_valid_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // R1 R2 R3 R4: three fields, unit stride
        run_ok("unit3", 32'h1000, 32'h0, 1'b0, 4'd4, 12'h400, 8'd4, 5'd3, 1'b0, 1'b0, 1'b0, 6'd32, 6'd32);
        // R5 R10: strided store with back-pressure
        run_ok("strided", 32'h8000, 32'h40, 1'b1, 4'd8, 12'h200, 8'd3, 5'd10, 1'b0, 1'b1, 1'b1, 6'd32, 6'd32);
        // R1: zero count field with low immediate bits set gives one field
        run_ok("single", 32'h300, 32'h0, 1'b0, 4'd2, 12'h1FF, 8'd5, 5'd7, 1'b0, 1'b0, 1'b1, 6'd32, 6'd32);
        // R12: wrap past the top of the address space
        run_ok("wrap", 32'hFFFF_FFF8, 32'h0, 1'b0, 4'd4, 12'h200, 8'd3, 5'd0, 1'b0, 1'b0, 1'b0, 6'd32, 6'd32);
        // R1: eight fields
        run_ok("eight", 32'h40, 32'h0, 1'b0, 4'd1, 12'hE00, 8'd2, 5'd8, 1'b0, 1'b1, 1'b0, 6'd32, 6'd32);
        t_zero_len();
        // R7: range ending at the last legal integer register
        run_ok("edge_int", 32'h500, 32'h0, 1'b0, 4'd4, 12'h400, 8'd1, 5'd29, 1'b0, 1'b0, 1'b0, 6'd32, 6'd8);
        // R7: one past the end
        run_fault("bad_int", 5'd30, 12'h400, 1'b0, 1'b1, 6'd32, 6'd32, 2'd2);
        // R8: floating-point count governs
        run_fault("bad_fp", 5'd14, 12'h400, 1'b1, 1'b1, 6'd32, 6'd16, 2'd2);
        run_ok("edge_fp", 32'h600, 32'h0, 1'b0, 4'd8, 12'h400, 8'd2, 5'd13, 1'b1, 1'b0, 1'b0, 6'd8, 6'd16);
        // R6: privilege fault wins over a bad range
        run_fault("priv", 5'd30, 12'h400, 1'b0, 1'b0, 6'd32, 6'd32, 2'd1);
        run_fault("priv_ok_regs", 5'd0, 12'h000, 1'b0, 1'b0, 6'd32, 6'd32, 2'd1);
        finish_run();
    end

endmodule